// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block is a clocked controller for an external asynchronous static RAM. A host hands it one word at a time through a valid/ready handshake. Each request carries an address, write data and a write flag. The controller then produces the active-low chip-select, output-enable and write-strobe signals. It also drives the address bus and the shared bidirectional data bus, with each phase lasting enough clock cycles to meet the memory's timing.

Every memory timing limit is a parameter given in nanoseconds. At elaboration the controller divides each limit by the clock period and rounds up to whole clock cycles. A read keeps select and output-enable low until the longest of the cycle, address-access and output-enable-access times has passed. It then captures the bus and returns the word with a one-cycle valid pulse. A write holds output-enable high, lowers select and the write strobe together, and drives the data for the whole strobe. The strobe is held for the longest of the pulse-width, data-setup, address-setup and write-cycle limits. After a read, the controller waits out the memory's output turn-off time before it may drive the bus again. All strobes come from flip-flops.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, chip-select, output-enable and write strobe are all high (inactive), the data bus is not driven, `reqReady` is high and `rspValid` is low.
- R2: A read keeps chip-select and output-enable low, with the write strobe high, for exactly RD_CYC clocks. RD_CYC is the largest of ceil(T_RC_NS/CLK_PERIOD_NS), ceil(T_AA_NS/CLK_PERIOD_NS) and ceil(T_DOE_NS/CLK_PERIOD_NS), and at least 1. The word on the bus at the end of that window appears on `rspRdata` with `rspValid` high for exactly one cycle.
- R3: A write keeps chip-select and write strobe low together for exactly WR_CYC clocks. WR_CYC is the largest of the rounded-up pulse-width, data-setup, address-setup and write-cycle limits, and at least 1. Output-enable stays high for the whole write.
- R4: During a write, the request's data is driven on the bus from the edge where the write strobe falls. It stays stable until the edge where the strobe rises, and the bus is released on that same edge.
- R5: The address bus takes the request's address on the edge that lowers chip-select. It does not change while chip-select stays low.
- R6: After output-enable rises at the end of a read, the controller leaves the bus undriven for at least TURN_CYC = ceil(T_HZOE_NS/CLK_PERIOD_NS) further clocks. The next write's strobe and data therefore follow the memory's bus release.
- R7: `reqReady` is high only when no memory cycle is in progress. A request presented while `reqReady` is low is not taken and leaves the memory contents unchanged.
- R8: Each nanosecond limit becomes ceil(limit / CLK_PERIOD_NS) clock cycles, and a limit of 0 ns adds no cycle. With a 10 ns clock and limits of 12, 12, 5, 8, 7, 8, 12 and 5 ns, RD_CYC = 2, WR_CYC = 2 and TURN_CYC = 1.
- R9: Requests may follow each other with no idle time on the host side. Chip-select returns high for at least one clock between two memory cycles, and every read returns the most recently written word at its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can take a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address of the request |
| reqWdata | input | DATA_W | Data for a write request |
| rspValid | output | 1 | One-cycle pulse: read data valid |
| rspRdata | output | DATA_W | Read data |
| sramCeN | output | 1 | Memory chip-select, active low |
| sramOeN | output | 1 | Memory output-enable, active low |
| sramWeN | output | 1 | Memory write strobe, active low |
| sramAddr | output | ADDR_W | Memory address bus |
| sramData | inout | DATA_W | Memory bidirectional data bus |

## Verification
Assertions watch several rules on every clock. Output-enable and the write strobe are never low together. The write strobe stays low for exactly WR_CYC clocks. The address holds while chip-select is low. `reqReady` is low during any memory cycle. The bus drive never starts sooner than TURN_CYC + 1 clocks after output-enable was last low. The valid pulse never lasts two cycles.

Other behaviours show only in the bench's scenarios. The bench uses a behavioural memory that measures strobe widths, data setup, address setup and output turn-off in nanoseconds. That is how it shows the timing margins, the data that reads return, and the effect of back-to-back and mixed read/write sequences. It also shows that a request offered while the controller is busy is dropped.

// File: rtl/asram_pkg.sv
package asram_pkg;

  // Memory-side strobes as registered by the control FSM (active-low pins).
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic drive;   // controller owns the data bus
  } pins_t;

  // Control-to-datapath strobe bundle.
  typedef struct packed {
    logic  load;     // latch request address/data
    logic  capture;  // sample the data bus into the read register
    pins_t pins;
  } ctl_t;

  // Round a nanosecond limit up to whole clock cycles.
  function automatic int nsToCycles(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int RD_CYC   = 2,
  parameter int WR_CYC   = 2,
  parameter int TURN_CYC = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  output logic reqReady,
  output ctl_t ctl
);

  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, WR_CYC), maxOf(TURN_CYC, 1));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(maxOf(TURN_CYC, 1) - 1);
  localparam pins_t PINS_IDLE  = '{ceN: 1'b1, oeN: 1'b1, weN: 1'b1, drive: 1'b0};
  localparam pins_t PINS_READ  = '{ceN: 1'b0, oeN: 1'b0, weN: 1'b1, drive: 1'b0};
  localparam pins_t PINS_WRITE = '{ceN: 1'b0, oeN: 1'b1, weN: 1'b0, drive: 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_TURN} state_t;

  state_t           state, stateD;
  logic [CNT_W-1:0] cnt, cntD;
  pins_t            pinsQ, pinsD;
  logic             accept;

  assign reqReady    = (state == S_IDLE);
  assign accept      = reqValid && reqReady;
  assign ctl.load    = accept;
  assign ctl.capture = (state == S_READ) && (cnt == RD_LAST);
  assign ctl.pins    = pinsQ;

  always_comb begin
    stateD = state;
    cntD   = cnt;
    pinsD  = pinsQ;
    case (state)
      S_IDLE: begin
        if (accept) begin
          cntD = '0;
          if (reqWrite) begin
            stateD = S_WRITE;
            pinsD  = PINS_WRITE;
          end else begin
            stateD = S_READ;
            pinsD  = PINS_READ;
          end
        end
      end
      S_READ: begin
        if (cnt == RD_LAST) begin
          pinsD  = PINS_IDLE;
          cntD   = '0;
          stateD = (TURN_CYC > 0) ? S_TURN : S_IDLE;
        end else begin
          cntD = cnt + 1'b1;
        end
      end
      S_WRITE: begin
        if (cnt == WR_LAST) begin
          pinsD  = PINS_IDLE;
          cntD   = '0;
          stateD = S_IDLE;
        end else begin
          cntD = cnt + 1'b1;
        end
      end
      S_TURN: begin
        if (cnt == TURN_LAST) begin
          cntD   = '0;
          stateD = S_IDLE;
        end else begin
          cntD = cnt + 1'b1;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      pinsQ <= PINS_IDLE;
    end else begin
      state <= stateD;
      cnt   <= cntD;
      pinsQ <= pinsD;
    end
  end

  // Width monitor for the write strobe, counted in clocks.
  logic [CNT_W:0] weLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                weLowCnt <= '0;
    else if (pinsQ.weN)       weLowCnt <= '0;
    else if (~&weLowCnt)      weLowCnt <= weLowCnt + 1'b1;
  end

  // R3
  we_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinsQ.weN) |-> (weLowCnt == (CNT_W+1)'(WR_CYC)));

  // R3
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!pinsQ.oeN && !pinsQ.weN));

  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pinsQ.ceN |-> !reqReady);

endmodule

// File: rtl/asram_ctrl_dp.sv
module asram_ctrl_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (ctl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
      rspQ   <= 1'b0;
    end else begin
      rspQ <= ctl.capture;
      if (ctl.capture) rdataQ <= dataIn;
    end
  end

  assign sramAddr = addrQ;
  assign dataOut  = wdataQ;
  assign dataOe   = ctl.pins.drive;
  assign sramCeN  = ctl.pins.ceN;
  assign sramOeN  = ctl.pins.oeN;
  assign sramWeN  = ctl.pins.weN;
  assign rspValid = rspQ;
  assign rspRdata = rdataQ;

  // Clocks since output-enable was last low, saturating; starts saturated.
  logic [15:0] oeHighCnt;
  localparam logic [15:0] TURN_MIN = 16'(TURN_CYC + 1);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               oeHighCnt <= '1;
    else if (!ctl.pins.oeN)  oeHighCnt <= '0;
    else if (~&oeHighCnt)    oeHighCnt <= oeHighCnt + 1'b1;
  end

  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> (oeHighCnt >= TURN_MIN));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R4
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe)) |-> $stable(dataOut));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 12,
  parameter int T_AA_NS       = 12,
  parameter int T_DOE_NS      = 5,
  parameter int T_PWE_NS      = 8,
  parameter int T_SD_NS       = 7,
  parameter int T_AW_NS       = 8,
  parameter int T_WC_NS       = 12,
  parameter int T_HZOE_NS     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [ADDR_W-1:0] sramAddr,
  inout  wire  [DATA_W-1:0] sramData
);

  localparam int RD_CYC = maxOf(1, maxOf(nsToCycles(T_RC_NS, CLK_PERIOD_NS),
                               maxOf(nsToCycles(T_AA_NS, CLK_PERIOD_NS),
                                     nsToCycles(T_DOE_NS, CLK_PERIOD_NS))));
  localparam int WR_CYC = maxOf(1, maxOf(maxOf(nsToCycles(T_PWE_NS, CLK_PERIOD_NS),
                                               nsToCycles(T_SD_NS, CLK_PERIOD_NS)),
                                         maxOf(nsToCycles(T_AW_NS, CLK_PERIOD_NS),
                                               nsToCycles(T_WC_NS, CLK_PERIOD_NS))));
  localparam int TURN_CYC = nsToCycles(T_HZOE_NS, CLK_PERIOD_NS);

  ctl_t              ctl;
  logic [DATA_W-1:0] dataOut;
  logic [DATA_W-1:0] dataIn;
  logic              dataOe;

  asram_ctrl_fsm #(
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .ctl     (ctl)
  );

  asram_ctrl_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .TURN_CYC(TURN_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe),
    .sramAddr(sramAddr),
    .sramCeN (sramCeN),
    .sramOeN (sramOeN),
    .sramWeN (sramWeN),
    .rspValid(rspValid),
    .rspRdata(rspRdata)
  );

  assign sramData = dataOe ? dataOut : {DATA_W{1'bz}};
  assign dataIn   = sramData;

endmodule

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int PER = 10;
  localparam int RD_CYC = 2;    // R8: max(ceil(12/10), ceil(12/10), ceil(5/10))
  localparam int WR_CYC = 2;    // R8: max(ceil(8/10), ceil(7/10), ceil(8/10), ceil(12/10))
  localparam real T_AA = 12.0, T_DOE = 5.0, T_PWE = 8.0, T_SD = 7.0;
  localparam real T_AWS = 8.0, T_HZOE = 5.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rspValid, sramCeN, sramOeN, sramWeN;
  logic [DW-1:0] rspRdata;
  logic [AW-1:0] sramAddr;
  wire  [DW-1:0] sramData;

  always #(PER/2) clk = ~clk;

  asram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER),
    .T_RC_NS(12), .T_AA_NS(12), .T_DOE_NS(5), .T_PWE_NS(8),
    .T_SD_NS(7), .T_AW_NS(8), .T_WC_NS(12), .T_HZOE_NS(5)
  ) u_asram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .sramCeN(sramCeN),
    .sramOeN(sramOeN), .sramWeN(sramWeN), .sramAddr(sramAddr),
    .sramData(sramData)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $realtime);
    end
  endtask

  // ---------------- behavioural memory with timing checks ----------------
  logic [DW-1:0] mem    [256];
  logic [DW-1:0] shadow [256];
  logic          armed = 1'b0;
  logic          memDrv = 1'b0;
  logic [DW-1:0] memVal = '0;
  logic [DW-1:0] prevBus = '0;
  logic [AW-1:0] prevAddr = '0;
  logic          oeLowInWrite = 1'b0;
  logic          cycWasWrite = 1'b0;
  realtime tAddr = 0, tChg = 0, tOeFall = -1000, tOeRise = -1000;
  realtime tWeFall = 0, tCeFall = 0;

  assign sramData = memDrv ? memVal : {DW{1'bz}};

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = DW'(16'h1000 + i * 3);
      shadow[i] = DW'(16'h1000 + i * 3);
    end
    #0.25;
    forever begin
      if (sramAddr !== prevAddr) tAddr = $realtime;
      if (sramData !== prevBus)  tChg  = $realtime;
      prevAddr = sramAddr;
      prevBus  = sramData;
      if (armed && !sramWeN && !sramOeN) oeLowInWrite = 1'b1;
      memDrv = armed && sramWeN &&
               ((!sramCeN && !sramOeN) || ($realtime - tOeRise < T_HZOE));
      if (!sramCeN && !sramOeN && ($realtime - tAddr >= T_AA) &&
          ($realtime - tOeFall >= T_DOE))
        memVal = mem[sramAddr];
      else
        memVal = 16'hDEAD;
      #0.5;
    end
  end

  always @(negedge sramOeN) tOeFall = $realtime;
  always @(posedge sramOeN) tOeRise = $realtime;
  always @(negedge sramCeN) tCeFall = $realtime;

  always @(negedge sramWeN) if (armed) begin
    tWeFall      = $realtime;
    cycWasWrite  = 1'b1;
    oeLowInWrite = 1'b0;
    // R6: memory output must already be off when the write starts
    check(sramOeN && ($realtime - tOeRise >= T_HZOE), "R6 turnaround",
          longint'($realtime - tOeRise), longint'(T_HZOE));
  end

  always @(posedge sramWeN) if (armed) begin
    // R3 / R8: strobe width equals WR_CYC clocks and meets the pulse limit
    check(($realtime - tWeFall >= T_PWE) && ($realtime - tWeFall == WR_CYC * PER),
          "R3/R8 write strobe width", longint'($realtime - tWeFall), WR_CYC * PER);
    check(!oeLowInWrite, "R3 output-enable high during write", oeLowInWrite, 0);
    // R4: data setup to the terminating edge
    check($realtime - tChg >= T_SD, "R4 data setup", longint'($realtime - tChg),
          longint'(T_SD));
    // R5: address setup to the end of the write
    check($realtime - tAddr >= T_AWS, "R5 address setup",
          longint'($realtime - tAddr), longint'(T_AWS));
    mem[prevAddr] = prevBus;
  end

  always @(posedge sramCeN) if (armed) begin
    // R5: address unchanged while select was low
    check(tAddr <= tCeFall + 0.3, "R5 address stable under select",
          longint'(tAddr), longint'(tCeFall));
    if (!cycWasWrite)
      // R2 / R8: read window length
      check($realtime - tCeFall == RD_CYC * PER, "R2/R8 read window",
            longint'($realtime - tCeFall), RD_CYC * PER);
    cycWasWrite = 1'b0;
  end

  // ---------------- scoreboard ----------------
  logic [DW-1:0] expQ [$];
  logic prevRsp = 1'b0;

  always @(negedge clk) if (armed) begin
    if (rspValid) begin
      check(!prevRsp, "R2 valid pulse single cycle", prevRsp, 0);
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected response", rspRdata, 0);
      end else begin
        logic [DW-1:0] e;
        e = expQ.pop_front();
        check(rspRdata == e, "R2/R9 read data", rspRdata, e);
      end
    end
    if (!sramCeN) check(!reqReady, "R7 ready low while busy", reqReady, 0);
    prevRsp = rspValid;
  end

  task automatic send(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (w) shadow[a] = d;
    else   expQ.push_back(shadow[a]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state while reset held
    check(sramCeN && sramOeN && sramWeN, "R1 strobes inactive in reset",
          {sramCeN, sramOeN, sramWeN}, 3'b111);
    check(reqReady, "R1 ready in reset", reqReady, 1);
    check(!rspValid, "R1 no response in reset", rspValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    armed = 1'b1;
    @(negedge clk);
    check(sramCeN && sramOeN && sramWeN && reqReady && !rspValid,
          "R1 state after reset", {sramCeN, sramOeN, sramWeN, reqReady, rspValid},
          5'b11110);
    check(sramData === 16'hzzzz || !sramOeN, "R1 bus undriven", sramData, 0);

    // R2: reads of untouched locations
    send(1'b0, 8'd5, '0);
    send(1'b0, 8'd250, '0);
    idle(4);

    // R3 / R4: isolated writes then reads
    send(1'b1, 8'd5, 16'hA5A5);
    idle(3);
    send(1'b1, 8'd6, 16'h5A5A);
    idle(3);
    send(1'b0, 8'd5, '0);
    idle(4);
    send(1'b0, 8'd6, '0);
    idle(4);

    // R9: back-to-back writes, then back-to-back reads, no host idle
    for (int i = 0; i < 8; i++) send(1'b1, AW'(i * 37), DW'(16'h1357 * (i + 1)));
    for (int i = 0; i < 8; i++) send(1'b0, AW'(i * 37), '0);

    // R6 / R9: alternating read and write without gaps
    for (int i = 0; i < 12; i++) begin
      send(1'b0, AW'(i * 11 + 1), '0);
      send(1'b1, AW'(i * 11 + 1), ~DW'(i * 16'h0F0F));
      send(1'b0, AW'(i * 11 + 1), '0);
    end
    idle(4);

    // R7: a request held while busy is dropped
    send(1'b0, 8'd77, '0);
    check(!reqReady, "R7 busy after accept", reqReady, 0);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 8'd90; reqWdata = 16'hBEEF;
    @(negedge clk);
    reqValid = 1'b0;
    idle(5);
    send(1'b0, 8'd90, '0);   // expects the untouched shadow value
    idle(6);

    check(expQ.size() == 0, "R2 all reads answered", expQ.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule